// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small accumulator processor. A microprogram held in an on-chip control store spells out, word by word, which datapath strobes fire in each clock cycle. A control address register selects the word to read. On every clock edge that word is copied into a control buffer register, and the buffer's outputs are the strobes themselves, so loading a word is the same as executing it. Every strobe set in one word fires in the same cycle.

Alongside each strobe pattern, a microinstruction carries a 3-bit condition code and a target address. The sequencing logic uses them to choose the next control address. The choices are the next word in order, the target when a datapath flag is set, the target with no condition, or an instruction's routine entry point. The entry point is looked up from the opcode byte of the instruction register.

The datapath is outside this block. It feeds back the opcode, the indirect-address bit and three status flags (accumulator zero, multiply complete, divide complete). For every word, the condition is resolved with the input values present at the clock edge that loads that word into the buffer.

Top module: `micro_sequencer`

## Requirements
- R1: While `rst` is high, the control address and the buffer are both zero and `ctrlLines` is 0x0000. The first rising edge after release loads word 0, so `ctrlLines` is 0x0001 in the first cycle.
- R2: On every rising edge, the buffer loads the strobe field of the word at the current control address. Every strobe of that word is asserted together, for exactly one cycle.
- R3: The strobe bit positions of `ctrlLines` are: 0 PC to MAR, 1 memory read, 2 memory write, 3 PC increment, 4 MBR to IR, 5 IR address to MAR, 6 MBR to IR address field, 7 MBR to BR, 8 ACC to MBR, 9 IR address to PC, 10 add, 11 subtract, 12 multiply, 13 divide, 14 AND, 15 OR.
- R4: Condition code 0 (sequential) moves to the next address and ignores every flag input.
- R5: Condition codes 1 (indirect bit), 4 (zero flag), 5 (multiply done) and 6 (divide done) load the target address when their own input is high at the loading edge. When that input is low, the address increments.
- R6: Condition code 2 loads the target address with no condition.
- R7: Condition code 3 loads the routine entry for the opcode. The entries are 0x02 store→16, 0x03 add→12, 0x04 subtract→48, 0x05 branch-if-zero→20, 0x06 jump→24, 0x07 multiply→28, 0x08 divide→36, 0x09 AND→44, 0x0A OR→52. Any other opcode maps to 0, which restarts the fetch.
- R8: The fetch routine at address 0 produces 0x0001, 0x000A, 0x0010, 0x0000, 0x0000. The fifth word tests the indirect bit. A direct instruction then shows one 0x0000 before its routine. An indirect one shows 0x0022, 0x0040, 0x0000, 0x0000 before its routine.
- R9: Each execute routine ends with an unconditional jump to address 0. The routines are: add/subtract/AND/OR 0x0022, 0x0080, then the ALU strobe; store 0x0120, 0x0004; jump 0x0200; branch-if-zero 0x0000 followed by 0x0200 if taken or 0x0000 if not. The fetch word 0x0001 follows directly.
- R10: Multiply and divide show 0x0022, 0x0080, the ALU strobe, 0x0000. They then stay in a two-word wait loop of 0x0000 words. The loop's test word re-checks the done flag every second cycle and returns to fetch as soon as that flag is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| opcode | input | 8 | Opcode byte of the instruction register |
| indFlag | input | 1 | Indirect-address bit of the current instruction |
| zeroFlag | input | 1 | Accumulator is zero |
| mpyDone | input | 1 | Multiplier has finished |
| divDone | input | 1 | Divider has finished |
| ctrlLines | output | 16 | Datapath strobes from the control buffer register |

## Verification
The bench targets the points where the next-address choice can go wrong:
- **Condition polarity on the zero branch.** A sequencer with the polarity inverted would jump on a clear flag, so the bench takes the branch-if-zero routine with the flag both set and clear.
- **Multiply wait loop.** The done flag is raised late, while the loop is on its non-testing word. A design that sampled the flag a cycle early or late would leave the loop one cycle off.
- **Indirect detour.** Running an indirect instruction shows whether the indirect bit is read only on its own test word.
- **Unknown opcode.** An opcode with no routine must go back to fetch rather than some stray address.
- **Flags on sequential words.** All flags are held high during a plain add, which shows up any sequential word that wrongly reacts to a flag.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [2:0] {
    COND_NEXT = 3'd0,
    COND_IND  = 3'd1,
    COND_JMP  = 3'd2,
    COND_MAP  = 3'd3,
    COND_ZERO = 3'd4,
    COND_MPY  = 3'd5,
    COND_DIV  = 3'd6
  } seqCond_e;

  // strobes from the branch decision into the address path
  typedef struct packed {
    logic takeJump;
    logic takeMap;
  } seqStrobes_t;

  // datapath strobe positions (R3)
  localparam logic [15:0] LN_PC_MAR   = 16'h0001;
  localparam logic [15:0] LN_MEM_RD   = 16'h0002;
  localparam logic [15:0] LN_MEM_WR   = 16'h0004;
  localparam logic [15:0] LN_PC_INC   = 16'h0008;
  localparam logic [15:0] LN_MBR_IR   = 16'h0010;
  localparam logic [15:0] LN_IRA_MAR  = 16'h0020;
  localparam logic [15:0] LN_MBR_IRA  = 16'h0040;
  localparam logic [15:0] LN_MBR_BR   = 16'h0080;
  localparam logic [15:0] LN_ACC_MBR  = 16'h0100;
  localparam logic [15:0] LN_IRA_PC   = 16'h0200;
  localparam logic [15:0] LN_ALU_ADD  = 16'h0400;
  localparam logic [15:0] LN_ALU_SUB  = 16'h0800;
  localparam logic [15:0] LN_ALU_MPY  = 16'h1000;
  localparam logic [15:0] LN_ALU_DIV  = 16'h2000;
  localparam logic [15:0] LN_ALU_AND  = 16'h4000;
  localparam logic [15:0] LN_ALU_OR   = 16'h8000;

endpackage

// File: rtl/useq_branch.sv
module useq_branch
  import useq_pkg::*;
(
  input  seqCond_e    cond,
  input  logic        indFlag,
  input  logic        zeroFlag,
  input  logic        mpyDone,
  input  logic        divDone,
  output seqStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    case (cond)
      COND_IND:  strobes.takeJump = indFlag;
      COND_JMP:  strobes.takeJump = 1'b1;
      COND_MAP:  strobes.takeMap  = 1'b1;
      COND_ZERO: strobes.takeJump = zeroFlag;
      COND_MPY:  strobes.takeJump = mpyDone;
      COND_DIV:  strobes.takeJump = divDone;
      default:   strobes = '0;
    endcase
  end

endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int AW     = 6,
  parameter int CTRL_W = 16,
  parameter int OPC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strobes,
  input  logic [OPC_W-1:0]  opcode,
  output seqCond_e          curCond,
  output logic [AW-1:0]     curNext,
  output logic [AW-1:0]     curAddr,
  output logic [CTRL_W-1:0] ctrlLines
);

  localparam int DEPTH  = 1 << AW;
  localparam int COND_W = 3;
  localparam int WORD_W = CTRL_W + COND_W + AW;

  function automatic logic [WORD_W-1:0] pack(input logic [15:0] c,
                                             input seqCond_e k, input int n);
    return {CTRL_W'(c), k, AW'(n)};
  endfunction

  // microprogram contents
  function automatic logic [WORD_W-1:0] romInit(input int a);
    case (a)
      0:  return pack(LN_PC_MAR, COND_NEXT, 0);
      1:  return pack(LN_MEM_RD | LN_PC_INC, COND_NEXT, 0);
      2:  return pack(LN_MBR_IR, COND_NEXT, 0);
      3:  return pack('0, COND_NEXT, 0);
      4:  return pack('0, COND_IND, 6);
      5:  return pack('0, COND_MAP, 0);
      6:  return pack(LN_IRA_MAR | LN_MEM_RD, COND_NEXT, 0);
      7:  return pack(LN_MBR_IRA, COND_NEXT, 0);
      8:  return pack('0, COND_NEXT, 0);
      9:  return pack('0, COND_MAP, 0);
      12: return pack(LN_IRA_MAR | LN_MEM_RD, COND_NEXT, 0);
      13: return pack(LN_MBR_BR, COND_NEXT, 0);
      14: return pack(LN_ALU_ADD, COND_JMP, 0);
      16: return pack(LN_IRA_MAR | LN_ACC_MBR, COND_NEXT, 0);
      17: return pack(LN_MEM_WR, COND_JMP, 0);
      20: return pack('0, COND_ZERO, 22);
      21: return pack('0, COND_JMP, 0);
      22: return pack(LN_IRA_PC, COND_JMP, 0);
      24: return pack(LN_IRA_PC, COND_JMP, 0);
      28: return pack(LN_IRA_MAR | LN_MEM_RD, COND_NEXT, 0);
      29: return pack(LN_MBR_BR, COND_NEXT, 0);
      30: return pack(LN_ALU_MPY, COND_NEXT, 0);
      31: return pack('0, COND_NEXT, 0);
      32: return pack('0, COND_MPY, 0);
      33: return pack('0, COND_JMP, 32);
      36: return pack(LN_IRA_MAR | LN_MEM_RD, COND_NEXT, 0);
      37: return pack(LN_MBR_BR, COND_NEXT, 0);
      38: return pack(LN_ALU_DIV, COND_NEXT, 0);
      39: return pack('0, COND_NEXT, 0);
      40: return pack('0, COND_DIV, 0);
      41: return pack('0, COND_JMP, 40);
      44: return pack(LN_IRA_MAR | LN_MEM_RD, COND_NEXT, 0);
      45: return pack(LN_MBR_BR, COND_NEXT, 0);
      46: return pack(LN_ALU_AND, COND_JMP, 0);
      48: return pack(LN_IRA_MAR | LN_MEM_RD, COND_NEXT, 0);
      49: return pack(LN_MBR_BR, COND_NEXT, 0);
      50: return pack(LN_ALU_SUB, COND_JMP, 0);
      52: return pack(LN_IRA_MAR | LN_MEM_RD, COND_NEXT, 0);
      53: return pack(LN_MBR_BR, COND_NEXT, 0);
      54: return pack(LN_ALU_OR, COND_JMP, 0);
      default: return pack('0, COND_NEXT, 0);
    endcase
  endfunction

  // opcode to routine entry
  function automatic logic [AW-1:0] mapEntry(input logic [OPC_W-1:0] op);
    case (int'(op))
      2:  return AW'(16);
      3:  return AW'(12);
      4:  return AW'(48);
      5:  return AW'(20);
      6:  return AW'(24);
      7:  return AW'(28);
      8:  return AW'(36);
      9:  return AW'(44);
      10: return AW'(52);
      default: return '0;
    endcase
  endfunction

  logic [WORD_W-1:0] romArr [DEPTH];
  logic [WORD_W-1:0] romOut;
  logic [CTRL_W-1:0] romCtrl;
  logic [AW-1:0]     carQ, nextAddr;
  logic [CTRL_W-1:0] cbrQ;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign romArr[i] = romInit(i);
  end

  assign romOut  = romArr[carQ];
  assign romCtrl = romOut[WORD_W-1 -: CTRL_W];
  assign curCond = seqCond_e'(romOut[AW +: COND_W]);
  assign curNext = romOut[AW-1:0];

  always_comb begin
    if (strobes.takeMap)       nextAddr = mapEntry(opcode);
    else if (strobes.takeJump) nextAddr = curNext;
    else                       nextAddr = carQ + AW'(1);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      carQ <= '0;
      cbrQ <= '0;
    end else begin
      carQ <= nextAddr;
      cbrQ <= romCtrl;
    end
  end

  assign curAddr   = carQ;
  assign ctrlLines = cbrQ;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (carQ == '0 && cbrQ == '0)); // R1

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (curCond == COND_NEXT) |=> (carQ == $past(carQ) + AW'(1))); // R4

  AST_UNCOND_TARGET: assert property (@(posedge clk) disable iff (rst)
    (curCond == COND_JMP) |=> (carQ == $past(curNext))); // R6

  AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.takeJump, strobes.takeMap})); // R7

endmodule

// File: rtl/micro_sequencer.sv
module micro_sequencer
  import useq_pkg::*;
#(
  parameter int AW     = 6,
  parameter int CTRL_W = 16,
  parameter int OPC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              indFlag,
  input  logic              zeroFlag,
  input  logic              mpyDone,
  input  logic              divDone,
  output logic [CTRL_W-1:0] ctrlLines
);

  seqStrobes_t   strobes;
  seqCond_e      curCond;
  logic [AW-1:0] curNext;
  logic [AW-1:0] curAddr;
  logic          flagSel;
  logic          isFlagCond;

  useq_branch u_branch (
    .cond     (curCond),
    .indFlag  (indFlag),
    .zeroFlag (zeroFlag),
    .mpyDone  (mpyDone),
    .divDone  (divDone),
    .strobes  (strobes)
  );

  useq_store #(.AW(AW), .CTRL_W(CTRL_W), .OPC_W(OPC_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .opcode    (opcode),
    .curCond   (curCond),
    .curNext   (curNext),
    .curAddr   (curAddr),
    .ctrlLines (ctrlLines)
  );

  // flag-tested conditions, seen from the ports
  assign isFlagCond = (curCond == COND_IND) || (curCond == COND_ZERO) ||
                      (curCond == COND_MPY) || (curCond == COND_DIV);
  assign flagSel = (curCond == COND_IND)  ? indFlag  :
                   (curCond == COND_ZERO) ? zeroFlag :
                   (curCond == COND_MPY)  ? mpyDone  : divDone;

  AST_FLAG_LOW_STEP: assert property (@(posedge clk) disable iff (rst)
    (isFlagCond && !flagSel) |=> (curAddr == $past(curAddr) + AW'(1))); // R5

  AST_FLAG_HIGH_JUMP: assert property (@(posedge clk) disable iff (rst)
    (isFlagCond && flagSel) |=> (curAddr == $past(curNext))); // R5

endmodule

// File: tb/micro_sequencer_bench.sv
module micro_sequencer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  opcode = 8'h00;
  logic        indFlag = 1'b0;
  logic        zeroFlag = 1'b0;
  logic        mpyDone = 1'b0;
  logic        divDone = 1'b0;
  logic [15:0] ctrlLines;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  micro_sequencer u_micro_sequencer (
    .clk(clk), .rst(rst), .opcode(opcode), .indFlag(indFlag),
    .zeroFlag(zeroFlag), .mpyDone(mpyDone), .divDone(divDone),
    .ctrlLines(ctrlLines)
  );

  task automatic checkNow(input logic [15:0] exp, input string tag);
    nChecks++;
    if (ctrlLines !== exp) begin
      nFail++;
      $display("FAIL %s: ctrlLines=%h expected %h", tag, ctrlLines, exp);
    end
  endtask

  task automatic expectNext(input logic [15:0] exp, input string tag);
    @(posedge clk);
    @(negedge clk);
    checkNow(exp, tag);
  endtask

  task automatic setInputs(input logic [7:0] op, input logic ind, input logic z,
                           input logic m, input logic d);
    opcode = op; indFlag = ind; zeroFlag = z; mpyDone = m; divDone = d;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic fetch(input bit ind);
    expectNext(16'h0001, "R8 fetch addr");
    expectNext(16'h000A, "R2 read+inc together");
    expectNext(16'h0010, "R8 load IR");
    expectNext(16'h0000, "R8 settle");
    expectNext(16'h0000, "R8 indirect test");
    if (ind) begin
      expectNext(16'h0022, "R5 indirect taken");
      expectNext(16'h0040, "R8 indirect address");
      expectNext(16'h0000, "R8 indirect settle");
      expectNext(16'h0000, "R8 indirect map");
    end else begin
      expectNext(16'h0000, "R5 indirect not taken");
    end
  endtask

  task automatic testReset();
    setInputs(8'h03, 1'b0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    checkNow(16'h0000, "R1 reset quiet");
    @(negedge clk);
    checkNow(16'h0000, "R1 reset held");
    rst = 1'b0;
    expectNext(16'h0001, "R1 first word");
  endtask

  task automatic testAlu(input logic [7:0] op, input logic [15:0] aluBit,
                         input bit ind);
    setInputs(op, ind, 1'b0, 1'b0, 1'b0);
    doReset();
    fetch(ind);
    expectNext(16'h0022, "R7 entry operand read");
    expectNext(16'h0080, "R9 operand to BR");
    expectNext(aluBit,   "R3 ALU strobe");
    expectNext(16'h0001, "R9 back to fetch");
  endtask

  task automatic testFlagsIgnored();
    setInputs(8'h03, 1'b0, 1'b1, 1'b1, 1'b1);
    doReset();
    fetch(1'b0);
    expectNext(16'h0022, "R4 flags ignored read");
    expectNext(16'h0080, "R4 flags ignored BR");
    expectNext(16'h0400, "R4 flags ignored add");
    expectNext(16'h0001, "R4 flags ignored refetch");
  endtask

  task automatic testStore();
    setInputs(8'h02, 1'b0, 1'b0, 1'b0, 1'b0);
    doReset();
    fetch(1'b0);
    expectNext(16'h0120, "R9 store addr+acc");
    expectNext(16'h0004, "R3 memory write");
    expectNext(16'h0001, "R9 store back to fetch");
  endtask

  task automatic testBranchZero(input logic z);
    setInputs(8'h05, 1'b0, z, 1'b0, 1'b0);
    doReset();
    fetch(1'b0);
    expectNext(16'h0000, "R5 zero test word");
    expectNext(z ? 16'h0200 : 16'h0000, z ? "R5 zero taken" : "R5 zero not taken");
    expectNext(16'h0001, "R6 branch back to fetch");
  endtask

  task automatic testJump();
    setInputs(8'h06, 1'b0, 1'b0, 1'b0, 1'b0);
    doReset();
    fetch(1'b0);
    expectNext(16'h0200, "R6 jump loads PC");
    expectNext(16'h0001, "R6 jump back to fetch");
  endtask

  task automatic testMpyWait();
    setInputs(8'h07, 1'b0, 1'b0, 1'b0, 1'b0);
    doReset();
    fetch(1'b0);
    expectNext(16'h0022, "R10 mpy read");
    expectNext(16'h0080, "R10 mpy BR");
    expectNext(16'h1000, "R10 mpy start");
    for (int k = 0; k < 5; k++) expectNext(16'h0000, "R10 mpy waiting");
    mpyDone = 1'b1;
    expectNext(16'h0000, "R10 mpy test word");
    expectNext(16'h0001, "R10 mpy exit to fetch");
  endtask

  task automatic testDivReady();
    setInputs(8'h08, 1'b0, 1'b0, 1'b0, 1'b1);
    doReset();
    fetch(1'b0);
    expectNext(16'h0022, "R10 div read");
    expectNext(16'h0080, "R10 div BR");
    expectNext(16'h2000, "R10 div start");
    expectNext(16'h0000, "R10 div settle");
    expectNext(16'h0000, "R5 div test word");
    expectNext(16'h0001, "R5 div done exit");
  endtask

  task automatic testUnmapped();
    setInputs(8'hFF, 1'b0, 1'b0, 1'b0, 1'b0);
    doReset();
    fetch(1'b0);
    expectNext(16'h0001, "R7 unmapped to fetch");
  endtask

  initial begin
    testReset();
    testAlu(8'h03, 16'h0400, 1'b0);
    testAlu(8'h03, 16'h0400, 1'b1);
    testAlu(8'h04, 16'h0800, 1'b0);
    testAlu(8'h09, 16'h4000, 1'b0);
    testAlu(8'h0A, 16'h8000, 1'b0);
    testFlagsIgnored();
    testStore();
    testBranchZero(1'b1);
    testBranchZero(1'b0);
    testJump();
    testMpyWait();
    testDivReady();
    testUnmapped();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule